// File: doc/BRIEF.md
# Pending Interrupt Priority Selector

This block holds one pending bit for each of thirteen asynchronous interrupt sources of a processor core. Each cycle it masks the pending vector with per-source enable conditions taken from the machine-state bits (external enable, critical enable, hypervisor state) and from two partition control bits. It then offers the single highest-priority eligible source to the exception sequencer as a source code with a valid/ready handshake. When the sequencer accepts, the block clears the accepted source's pending bit if that source's rule says so.

Requests arrive as one-cycle set pulses on a request vector. Explicit per-source clear pulses come from the source owners. A small message port sets or clears the doorbell and critical-doorbell bits of this core, either by identifier match or by broadcast. A power-save entry strobe discards any pending hypervisor decrementer request. A set in the same cycle as any clear of the same bit always wins.

Top module: `irq_prio_sel`

## Requirements
- R1: `irq_code_o` gives the index of the lowest-numbered source that is both pending and eligible. Indices in falling priority are: 0 reset, 1 machine check, 2 hypervisor decrementer, 3 external, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 doorbell, 11 performance monitor, 12 thermal.
- R2: Sources 0 and 1 are eligible whatever the enables are, and acceptance clears them.
- R3: Source 2 is eligible only when `hdec_en_i` is 1 and either `ee_i` is 1 or `hv_i` is 0. Acceptance clears it.
- R4: Source 3 is eligible when `ee_i` is 1. It is also eligible when the `HAS_HV` parameter is 1, `hv_i` is 0 and `ext_route_i` is 0. Acceptance does not clear it.
- R5: Source 4 is eligible only when `ce_i` is 1. Acceptance does not clear it.
- R6: Sources 5 to 12 are eligible only when `ee_i` is 1. Acceptance clears each of them, with source 9 as the exception given in R7.
- R7: Acceptance clears source 9 only while `dec_clr_cfg_i` is 1.
- R8: A message is addressed to this core when `msg_valid_i` is 1 and either `msg_bcast_i` is 1 or `msg_tag_i` equals `core_id_i`. For an addressed message, type 0 sets bit 10, type 1 clears bit 10, type 2 sets bit 6 and type 3 clears bit 6. Types 4 to 7 change nothing.
- R9: `pwr_save_i` high clears the pending bit of source 2 at the next edge.
- R10: Reset empties the pending vector, and `irq_valid_o` stays low until a request arrives.
- R11: A request on `req_i` sets its bit even if a clear of that bit (from `req_clr_i`, a message, acceptance or power save) arrives in the same cycle.
- R12: At most one source is offered per cycle. A pending bit changes on acceptance (`irq_valid_o` and `irq_ready_i` both high) only. While `irq_ready_i` is low, with no requests or clears, the offered code holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 13 | Per-source set pulses, bit index as in R1 |
| req_clr_i | input | 13 | Per-source clear pulses |
| ee_i | input | 1 | External-enable machine-state bit |
| ce_i | input | 1 | Critical-enable machine-state bit |
| hv_i | input | 1 | Core is in hypervisor state |
| hdec_en_i | input | 1 | Hypervisor decrementer enable |
| ext_route_i | input | 1 | External routing bit; 0 lets externals bypass `ee_i` outside hypervisor state |
| dec_clr_cfg_i | input | 1 | Decrementer clear-on-acceptance select |
| pwr_save_i | input | 1 | Power-save entry strobe |
| core_id_i | input | ID_W | Identifier of this core |
| msg_valid_i | input | 1 | Doorbell message strobe |
| msg_type_i | input | 3 | Message type (R8) |
| msg_bcast_i | input | 1 | Message addressed to all cores |
| msg_tag_i | input | ID_W | Message target identifier |
| irq_ready_i | input | 1 | Sequencer accepts the offered source |
| irq_valid_o | output | 1 | A source is offered |
| irq_code_o | output | 4 | Index of the offered source |

## Verification
The assertions assume that the enable and configuration inputs change only between clock edges. They also assume that `core_id_i` is held constant, and that `irq_ready_i` is a plain level the sequencer drives without looking ahead at the pending state. The bench drives every input once per cycle, just after the falling edge, and never touches `core_id_i` after reset. It keeps request and clear pulses sparse so that deliveries, retention and priority crossings all occur. Message tags are drawn from a small range so that identifier hits, misses, broadcasts and the unused message types each come up often.

// File: rtl/irq_prio_pkg.sv
`timescale 1ns/1ps
package irq_prio_pkg;
  localparam int NUM_SRC = 13;
  localparam int CODE_W  = $clog2(NUM_SRC);

  typedef enum logic [CODE_W-1:0] {
    SRC_RST   = 4'd0,
    SRC_MCK   = 4'd1,
    SRC_HDEC  = 4'd2,
    SRC_EXT   = 4'd3,
    SRC_CEXT  = 4'd4,
    SRC_WDT   = 4'd5,
    SRC_CDB   = 4'd6,
    SRC_FIT   = 4'd7,
    SRC_PIT   = 4'd8,
    SRC_DEC   = 4'd9,
    SRC_DB    = 4'd10,
    SRC_PERF  = 4'd11,
    SRC_THERM = 4'd12
  } src_e;

  typedef enum logic [2:0] {
    MSG_DB_SET  = 3'd0,
    MSG_DB_CLR  = 3'd1,
    MSG_CDB_SET = 3'd2,
    MSG_CDB_CLR = 3'd3
  } msg_e;
endpackage

// File: rtl/irq_pend_reg.sv
`timescale 1ns/1ps
module irq_pend_reg #(
  parameter int N = 13
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] pend_d;
  logic         upd_en;

  // set has precedence over clear
  always_comb begin
    pend_d = (pend_o & ~clr_i) | set_i;
    upd_en = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o <= '0;
    end else if (upd_en) begin
      pend_o <= pend_d;
    end
  end
endmodule

// File: rtl/irq_gate.sv
`timescale 1ns/1ps
module irq_gate
  import irq_prio_pkg::*;
#(
  parameter bit HAS_HV = 1'b1
) (
  input  logic               ee_i,
  input  logic               ce_i,
  input  logic               hv_i,
  input  logic               hdec_en_i,
  input  logic               ext_route_i,
  input  logic               dec_clr_cfg_i,
  output logic [NUM_SRC-1:0] elig_o,
  output logic [NUM_SRC-1:0] auto_clr_o
);
  localparam logic HV_CAP = HAS_HV;

  always_comb begin
    elig_o             = {NUM_SRC{ee_i}};
    elig_o[SRC_RST]    = 1'b1;
    elig_o[SRC_MCK]    = 1'b1;
    elig_o[SRC_HDEC]   = hdec_en_i & (ee_i | ~hv_i);
    elig_o[SRC_EXT]    = ee_i | (HV_CAP & ~hv_i & ~ext_route_i);
    elig_o[SRC_CEXT]   = ce_i;

    auto_clr_o           = '1;
    auto_clr_o[SRC_EXT]  = 1'b0;
    auto_clr_o[SRC_CEXT] = 1'b0;
    auto_clr_o[SRC_DEC]  = dec_clr_cfg_i;
  end
endmodule

// File: rtl/irq_pick.sv
`timescale 1ns/1ps
module irq_pick #(
  parameter int N = 13,
  parameter int W = $clog2(N)
) (
  input  logic [N-1:0] cand_i,
  output logic         valid_o,
  output logic [N-1:0] sel_o,
  output logic [W-1:0] idx_o
);
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign sel_o[gi]    = cand_i[gi] & ~seen[gi];
      assign seen[gi + 1] = seen[gi] | cand_i[gi];
    end
  endgenerate

  assign valid_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_o[i]) idx_o = idx_o | W'(i);
    end
  end
endmodule

// File: rtl/irq_msg_dec.sv
`timescale 1ns/1ps
module irq_msg_dec
  import irq_prio_pkg::*;
#(
  parameter int ID_W = 4
) (
  input  logic               msg_valid_i,
  input  logic [2:0]         msg_type_i,
  input  logic               msg_bcast_i,
  input  logic [ID_W-1:0]    msg_tag_i,
  input  logic [ID_W-1:0]    core_id_i,
  output logic [NUM_SRC-1:0] set_o,
  output logic [NUM_SRC-1:0] clr_o
);
  logic hit;

  always_comb begin
    hit   = msg_valid_i & (msg_bcast_i | (msg_tag_i == core_id_i));
    set_o = '0;
    clr_o = '0;
    case (msg_e'(msg_type_i))
      MSG_DB_SET:  set_o[SRC_DB]  = hit;
      MSG_DB_CLR:  clr_o[SRC_DB]  = hit;
      MSG_CDB_SET: set_o[SRC_CDB] = hit;
      MSG_CDB_CLR: clr_o[SRC_CDB] = hit;
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_prio_sel.sv
`timescale 1ns/1ps
module irq_prio_sel
  import irq_prio_pkg::*;
#(
  parameter int ID_W   = 4,
  parameter bit HAS_HV = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic [NUM_SRC-1:0] req_clr_i,
  input  logic               ee_i,
  input  logic               ce_i,
  input  logic               hv_i,
  input  logic               hdec_en_i,
  input  logic               ext_route_i,
  input  logic               dec_clr_cfg_i,
  input  logic               pwr_save_i,
  input  logic [ID_W-1:0]    core_id_i,
  input  logic               msg_valid_i,
  input  logic [2:0]         msg_type_i,
  input  logic               msg_bcast_i,
  input  logic [ID_W-1:0]    msg_tag_i,
  input  logic               irq_ready_i,
  output logic               irq_valid_o,
  output logic [CODE_W-1:0]  irq_code_o
);
  logic [NUM_SRC-1:0] pend_q;
  logic [NUM_SRC-1:0] elig, auto_clr, cand, sel;
  logic [NUM_SRC-1:0] msg_set, msg_clr, pwr_clr, dlv_clr;
  logic [NUM_SRC-1:0] set_all, clr_all;
  logic               accept;

  irq_gate #(.HAS_HV(HAS_HV)) u_gate (
    .ee_i          (ee_i),
    .ce_i          (ce_i),
    .hv_i          (hv_i),
    .hdec_en_i     (hdec_en_i),
    .ext_route_i   (ext_route_i),
    .dec_clr_cfg_i (dec_clr_cfg_i),
    .elig_o        (elig),
    .auto_clr_o    (auto_clr)
  );

  assign cand = pend_q & elig;

  irq_pick #(.N(NUM_SRC), .W(CODE_W)) u_pick (
    .cand_i  (cand),
    .valid_o (irq_valid_o),
    .sel_o   (sel),
    .idx_o   (irq_code_o)
  );

  irq_msg_dec #(.ID_W(ID_W)) u_msg (
    .msg_valid_i (msg_valid_i),
    .msg_type_i  (msg_type_i),
    .msg_bcast_i (msg_bcast_i),
    .msg_tag_i   (msg_tag_i),
    .core_id_i   (core_id_i),
    .set_o       (msg_set),
    .clr_o       (msg_clr)
  );

  always_comb begin
    accept            = irq_valid_o & irq_ready_i;
    dlv_clr           = accept ? (sel & auto_clr) : '0;
    pwr_clr           = '0;
    pwr_clr[SRC_HDEC] = pwr_save_i;
    set_all           = req_i | msg_set;
    clr_all           = req_clr_i | msg_clr | dlv_clr | pwr_clr;
  end

  irq_pend_reg #(.N(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (set_all),
    .clr_i  (clr_all),
    .pend_o (pend_q)
  );
endmodule

// File: rtl/irq_prio_sel_chk.sv
`timescale 1ns/1ps
module irq_prio_sel_chk
  import irq_prio_pkg::*;
#(
  parameter bit HAS_HV = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic [NUM_SRC-1:0] req_clr_i,
  input logic               ee_i,
  input logic               ce_i,
  input logic               hv_i,
  input logic               hdec_en_i,
  input logic               ext_route_i,
  input logic               pwr_save_i,
  input logic               msg_valid_i,
  input logic               irq_ready_i,
  input logic               irq_valid_o,
  input logic [CODE_W-1:0]  irq_code_o,
  input logic [NUM_SRC-1:0] pend_q
);
  localparam logic HV_CAP = HAS_HV;

  AST_CODE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid_o |-> pend_q[irq_code_o]); // R1
  AST_RST_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q[SRC_RST] |-> (irq_valid_o && irq_code_o == SRC_RST)); // R2
  AST_MCK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i && irq_code_o == SRC_MCK && !req_i[SRC_MCK])
      |=> !pend_q[SRC_MCK]); // R2
  AST_HDEC_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_code_o == SRC_HDEC) |-> (hdec_en_i && (ee_i || !hv_i))); // R3
  AST_EXT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_code_o == SRC_EXT)
      |-> (ee_i || (HV_CAP && !hv_i && !ext_route_i))); // R4
  AST_EXT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i && irq_code_o == SRC_EXT && !req_clr_i[SRC_EXT])
      |=> pend_q[SRC_EXT]); // R4
  AST_CRIT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_i |-> !(irq_valid_o && irq_code_o == SRC_CEXT)); // R5
  AST_CRIT_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i && irq_code_o == SRC_CEXT && !req_clr_i[SRC_CEXT])
      |=> pend_q[SRC_CEXT]); // R5
  AST_WDT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && irq_ready_i && irq_code_o == SRC_WDT && !req_i[SRC_WDT])
      |=> !pend_q[SRC_WDT]); // R6
  AST_PWR_HDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_save_i && !req_i[SRC_HDEC]) |=> !pend_q[SRC_HDEC]); // R9
  AST_HOLD_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid_o && !irq_ready_i && !pwr_save_i && !msg_valid_i && req_clr_i == '0)
      |=> pend_q[$past(irq_code_o)]); // R12

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SRC; gi++) begin : g_win
      AST_REQ_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        req_i[gi] |=> pend_q[gi]); // R11
    end
  endgenerate
endmodule

bind irq_prio_sel irq_prio_sel_chk #(.HAS_HV(HAS_HV)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_i       (req_i),
  .req_clr_i   (req_clr_i),
  .ee_i        (ee_i),
  .ce_i        (ce_i),
  .hv_i        (hv_i),
  .hdec_en_i   (hdec_en_i),
  .ext_route_i (ext_route_i),
  .pwr_save_i  (pwr_save_i),
  .msg_valid_i (msg_valid_i),
  .irq_ready_i (irq_ready_i),
  .irq_valid_o (irq_valid_o),
  .irq_code_o  (irq_code_o),
  .pend_q      (pend_q)
);

// File: tb/test_irq_prio_sel.sv
`timescale 1ns/1ps
module test_irq_prio_sel;
  localparam int N    = 13;
  localparam int ID_W = 4;
  localparam logic [ID_W-1:0] MY_ID = 4'd5;

  logic clk = 1'b0;
  logic rst_n;
  always #2 clk = ~clk;

  logic [N-1:0]    req, rclr;
  logic            ee, ce, hv, hdec_en, route, dcfg, pwr;
  logic            mval, mbc, rdy;
  logic [2:0]      mtyp;
  logic [ID_W-1:0] mtag;
  logic            vld;
  logic [3:0]      code;

  irq_prio_sel #(.ID_W(ID_W), .HAS_HV(1'b1)) i_irq_prio_sel (
    .clk(clk), .rst_n(rst_n), .req_i(req), .req_clr_i(rclr),
    .ee_i(ee), .ce_i(ce), .hv_i(hv), .hdec_en_i(hdec_en),
    .ext_route_i(route), .dec_clr_cfg_i(dcfg), .pwr_save_i(pwr),
    .core_id_i(MY_ID), .msg_valid_i(mval), .msg_type_i(mtyp),
    .msg_bcast_i(mbc), .msg_tag_i(mtag), .irq_ready_i(rdy),
    .irq_valid_o(vld), .irq_code_o(code)
  );

  int checks = 0;
  int errors = 0;
  logic [N-1:0] m_pend;

  function automatic logic [N-1:0] eligible();
    logic [N-1:0] e;
    e    = {N{ee}};
    e[0] = 1'b1;
    e[1] = 1'b1;
    e[2] = hdec_en & (ee | ~hv);
    e[3] = ee | (~hv & ~route);
    e[4] = ce;
    return e;
  endfunction

  function automatic int pick(logic [N-1:0] c);
    for (int i = 0; i < N; i++) if (c[i]) return i;
    return -1;
  endfunction

  function automatic string tag_of(int s);
    case (s)
      0, 1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      9: return "R7";
      6, 10: return "R8";
      -1: return "R12";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string rq, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", rq, got, exp);
    end
  endtask

  task automatic idle();
    req = '0; rclr = '0; pwr = 1'b0; mval = 1'b0; mbc = 1'b0;
    mtyp = 3'd0; mtag = '0; rdy = 1'b0;
  endtask

  // inputs already driven after a falling edge; check, then advance one cycle
  task automatic step(string rq = "", int ev = -1, int ec = -1);
    logic [N-1:0] setm, clrm;
    logic         hit;
    int           w;
    #1;
    w = pick(m_pend & eligible());
    chk((w < 0) ? "R1" : tag_of(w), int'(vld), int'(w >= 0));
    if (w >= 0) chk("R1", int'(code), w);
    if (rq != "") begin
      chk(rq, int'(vld), ev);
      if (ev == 1) chk(rq, int'(code), ec);
    end
    setm = req;
    clrm = rclr;
    hit  = mval & (mbc | (mtag == MY_ID));
    if (hit) begin
      case (mtyp)
        3'd0: setm[10] = 1'b1;
        3'd1: clrm[10] = 1'b1;
        3'd2: setm[6]  = 1'b1;
        3'd3: clrm[6]  = 1'b1;
        default: ;
      endcase
    end
    if (pwr) clrm[2] = 1'b1;
    if (w >= 0 && rdy && w != 3 && w != 4 && (w != 9 || dcfg)) clrm[w] = 1'b1;
    @(posedge clk);
    m_pend = (m_pend & ~clrm) | setm;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL R12 watchdog expired actual 0 expected 1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    idle();
    ee = 0; ce = 0; hv = 1; hdec_en = 0; route = 1; dcfg = 0;
    m_pend = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 chk("R10 valid in reset", int'(vld), 0);
    @(negedge clk);
    rst_n = 1'b1;
    step("R10 after release", 0);

    // R2: unconditional reset then machine check, both cleared
    req = '1; step();
    rdy = 1; step("R2 reset first", 1, 0);
    rdy = 1; step("R2 machine check next", 1, 1);
    step("R6 all gated off", 0);
    rclr = '1; step();

    // R4: external bypasses ee outside hypervisor state, retained
    req[3] = 1; step();
    hv = 0; route = 0; rdy = 1; step("R4 routed external", 1, 3);
    hv = 0; route = 0; step("R4 retained after accept", 1, 3);
    hv = 0; route = 1; step("R4 route bit blocks", 0);
    rclr[3] = 1; step();
    hv = 1;

    // R5: critical retained
    req[4] = 1; step();
    ce = 1; rdy = 1; step("R5 critical", 1, 4);
    step("R5 critical retained", 1, 4);
    ce = 0; step("R5 ce low blocks", 0);
    rclr[4] = 1; step();

    // R7: decrementer clear config
    ee = 1; dcfg = 0;
    req[9] = 1; step();
    rdy = 1; step("R7 dec offered", 1, 9);
    dcfg = 1; rdy = 1; step("R7 dec kept when cfg low", 1, 9);
    step("R7 dec cleared when cfg high", 0);

    // R8: doorbell messages
    mval = 1; mtyp = 3'd0; mtag = 4'd3; step();
    step("R8 tag mismatch ignored", 0);
    mval = 1; mtyp = 3'd0; mtag = MY_ID; step();
    mval = 1; mtyp = 3'd5; mtag = MY_ID; step("R8 tag match sets", 1, 10);
    mval = 1; mtyp = 3'd1; mbc = 1; mtag = 4'd9; step("R8 unknown type ignored", 1, 10);
    mval = 1; mtyp = 3'd2; mbc = 1; step("R8 broadcast clear", 0);
    mval = 1; mtyp = 3'd3; mtag = 4'd1; step("R8 broadcast sets critical doorbell", 1, 6);
    mval = 1; mtyp = 3'd3; mtag = MY_ID; step("R8 mismatch clear ignored", 1, 6);
    step("R8 critical doorbell cleared", 0);

    // R3 and R9
    ee = 0; hv = 0; hdec_en = 1;
    req[2] = 1; step();
    step("R3 hdec offered", 1, 2);
    hv = 1; step("R3 hdec blocked in hv state", 0);
    hv = 0; pwr = 1; step("R3 hdec offered again", 1, 2);
    step("R9 power save discarded hdec", 0);

    // R11: request beats clear
    ee = 1;
    req[12] = 1; rclr[12] = 1; step();
    req[12] = 1; rdy = 1; step("R11 request won over clear", 1, 12);
    step("R11 request won over acceptance", 1, 12);
    // R12: hold while not ready
    step("R12 held", 1, 12);
    rdy = 1; step("R12 held until accept", 1, 12);
    step("R12 cleared after accept", 0);

    // R1: priority among the ee group
    req[5] = 1; req[8] = 1; req[11] = 1; step();
    rdy = 1; step("R1 watchdog first", 1, 5);
    rdy = 1; step("R1 interval timer next", 1, 8);
    rdy = 1; step("R1 perf monitor last", 1, 11);
    step("R1 drained", 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      req   = N'($urandom & $urandom & $urandom & $urandom);
      rclr  = N'($urandom & $urandom & $urandom & $urandom);
      ee    = 1'($urandom);
      ce    = 1'($urandom);
      hv    = 1'($urandom);
      hdec_en = 1'($urandom);
      route = 1'($urandom);
      if (($urandom & 15) == 0) dcfg = 1'($urandom);
      pwr   = (($urandom & 31) == 0);
      mval  = (($urandom & 3) == 0);
      mtyp  = 3'($urandom);
      mbc   = (($urandom & 7) == 0);
      mtag  = 4'(3 + ($urandom & 3));
      rdy   = (($urandom & 3) != 0);
      step();
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule